// File: doc/BRIEF.md
# HDLC Receive Frame Error Detector

This block follows the flag-detection and zero-deletion stage of an HDLC receiver. Each cycle it may receive one line bit. A qualifier tells it whether the bit is frame content or a stuffed zero that the upstream stage has already removed. The upstream stage also supplies a frame-start pulse, a frame-end pulse carrying a CRC-valid flag, and the carrier-detect level.

The block collects the content bits into data words, first bit in the most significant position. When a frame closes, it classifies how the frame ended. From most to least severe, the classes are:

- carrier lost,
- abort run,
- non-octet length,
- CRC failure.

Only the most severe class that applies is reported.

On every frame close the block presents a registered status word together with a one-cycle done strobe. When the close is caused by an error it also produces:

- a receive-frame interrupt pulse, gated by an enable input,
- an increment strobe for the abort counter or the CRC-error counter, whichever applies,
- a request for the flag hunter to resume hunting.

When a frame ends with a partial octet, the residue is packed into the last data word: the valid bits are followed by a single 1 marker and zero fill down to the next octet boundary.

Top module: `hdlc_rx_err_detect`

## Requirements
- R1: After reset, `wr_en`, `done`, `stat`, `irq`, `abort_inc`, `crc_inc` and `hunt_req` are all zero.
- R2: Packing of content bits:
  - A line bit with `line_vld=1` and `line_keep=1` inside a frame is packed MSB-first into a WORD_W-bit word. The word is written (`wr_en` for one cycle) in the cycle after its last bit.
  - Bits with `line_keep=0` are not packed.
  - On a normal frame end, a partial word whose length is a whole number of octets is written right-justified with zeros above.
- R3: Carrier loss:
  - With `cd_hw_mode=1`, `carrier=0` in any cycle of an open frame closes that frame on the next clock edge. The close shows `done=1` with only `stat[3]` set and `hunt_req=1`.
  - The partial word is discarded, and the bit carried in that cycle is not packed.
  - With `cd_hw_mode=0`, `carrier` has no effect.
- R4: Abort run:
  - The seventh consecutive line bit equal to 1 inside a frame closes the frame. The close shows `done=1`, `stat=4'b0100`, `abort_inc=1` and `hunt_req=1`.
  - A line zero, including a deleted stuffed zero, breaks the run.
  - The partial word is discarded, and nothing is written or reported until the next `frame_start`.
- R5: If carrier loss and the seventh one fall in the same cycle, only carrier loss is reported (`stat=4'b1000`, `abort_inc=0`).
- R6: A frame end whose packed bit count is not a multiple of 8 reports `stat=4'b0010`, writes its data, and never raises `crc_inc`, whatever the value of `crc_ok`.
- R7: In the last word of a non-octet frame with k bits pending, the pending bits are shifted left by p = 8 - (k mod 8). Bit p-1 is set to 1, and all other bits are zero.
- R8: An octet-aligned frame end with `crc_ok=0` writes its pending data (the received CRC) and reports `stat=4'b0001` with `crc_inc=1`.
- R9: An octet-aligned frame end with `crc_ok=1` reports `done=1` with `stat=0`, and no `irq`, `hunt_req` or counter strobe.
- R10: `irq` pulses with `done` for every error-class close when `irq_en` was 1 in the closing cycle, and never otherwise.
- R11: `frame_start` in the same cycle as `frame_end` opens a new frame that is captured completely.
- R12: The status bits are `stat[3]` carrier lost, `stat[2]` abort, `stat[1]` non-octet and `stat[0]` CRC error. At most one of them is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cd_hw_mode | input | 1 | 1: carrier loss ends a frame |
| carrier | input | 1 | Carrier-detect level, 1 = present |
| irq_en | input | 1 | Receive-frame interrupt enable |
| frame_start | input | 1 | Opening flag seen; carries no bit |
| frame_end | input | 1 | Closing flag seen; carries no bit |
| crc_ok | input | 1 | CRC check result, valid with `frame_end` |
| line_vld | input | 1 | A line bit is present this cycle |
| line_bit | input | 1 | Line bit value |
| line_keep | input | 1 | 1: content bit, 0: deleted stuffed zero |
| wr_en | output | 1 | Data word write strobe |
| wr_data | output | WORD_W | Data word |
| done | output | 1 | Frame closed, `stat` valid |
| stat | output | 4 | Close status (see R12) |
| irq | output | 1 | Receive-frame interrupt pulse |
| abort_inc | output | 1 | Abort counter increment |
| crc_inc | output | 1 | CRC error counter increment |
| hunt_req | output | 1 | Return-to-hunt request |

## Verification
The hardest situations to reach are the ones that depend on where a frame ends relative to the word boundary and the octet boundary. These include:

- a word completing during the ones of an abort run,
- a carrier drop landing on the seventh one,
- a non-octet residue in every position of the word.

The bench sweeps frame lengths from 1 to 40 bits under three bit patterns. One of these patterns is all ones, which forces stuffed zeros that must break the run. It also sweeps the number of bits before every abort and carrier drop. Back-to-back frames and the interrupt enable are interleaved through the sweep.

// File: rtl/hdlc_rxe_pkg.sv
// Package: shared status layout for the HDLC receive error detector.
// Assumes the status bit order below is decoded by the buffer-closing logic.
package hdlc_rxe_pkg;
    localparam int STAT_W    = 4;
    localparam int ST_CD_BIT = 3;
    localparam int ST_AB_BIT = 2;
    localparam int ST_NO_BIT = 1;
    localparam int ST_CR_BIT = 0;

    typedef struct packed {
        logic cd_lost;
        logic aborted;
        logic non_octet;
        logic crc_bad;
    } rx_stat_t;
endpackage

// File: rtl/hdlc_rxe_ones_run.sv
// Module: counts consecutive line ones inside an open frame.
// Raises hit in the cycle that carries the RUN_LIMIT-th one.
// Assumes any line zero, deleted or not, is presented as a line bit.
module hdlc_rxe_ones_run #(
    parameter int RUN_LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic vld,
    input  logic bit_in,
    output logic hit
);
    localparam int CW = $clog2(RUN_LIMIT + 1);

    logic [CW-1:0] run_q;

    // Flags the bit that completes the run.
    always_comb begin
        hit = en && vld && bit_in && (run_q == CW'(RUN_LIMIT - 1));
    end

    // Saturating run length of ones; cleared by a zero or a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr) begin
            run_q <= '0;
        end else if (en && vld) begin
            if (!bit_in)
                run_q <= '0;
            else if (run_q != CW'(RUN_LIMIT))
                run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_rxe_packer.sv
// Module: packs content bits MSB-first into words.
// Writes a full word in the cycle after its last bit. On flush, it writes the
// pending bits, padding a partial octet with a 1 marker and zero fill.
// Assumes WORD_W is a multiple of 8, and that push and flush never coincide.
module hdlc_rxe_packer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              bit_in,
    input  logic              flush,
    output logic              non_octet,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data
);
    localparam int CW = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sr_q;
    logic [CW-1:0]     cnt_q;
    logic [2:0]        res;
    logic [3:0]        pad_n;
    logic [WORD_W-1:0] padded;
    logic [WORD_W-1:0] flush_word;

    // Residue and padded final word derived from the pending bits.
    always_comb begin
        res        = cnt_q[2:0];
        non_octet  = (res != 3'd0);
        pad_n      = 4'd8 - {1'b0, res};
        padded     = (sr_q << pad_n) | (WORD_W'(1) << (pad_n - 4'd1));
        flush_word = non_octet ? padded : sr_q;
    end

    // Shift register, fill count and the registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (push) begin
                if (cnt_q == CW'(WORD_W - 1)) begin
                    wr_en   <= 1'b1;
                    wr_data <= {sr_q[WORD_W-2:0], bit_in};
                    sr_q    <= '0;
                    cnt_q   <= '0;
                end else begin
                    sr_q  <= {sr_q[WORD_W-2:0], bit_in};
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (flush) begin
                if (cnt_q != '0) begin
                    wr_en   <= 1'b1;
                    wr_data <= flush_word;
                end
                sr_q  <= '0;
                cnt_q <= '0;
            end
            if (clr) begin
                sr_q  <= '0;
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/hdlc_rxe_classify.sv
// Module: turns the close events of a frame into a registered status word and
// one-cycle strobes.
// Priority: carrier loss, then abort, then non-octet, then CRC.
// Assumes at most one of cd_err, ab_err and end_evt is set in a cycle.
module hdlc_rxe_classify
    import hdlc_rxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cd_err,
    input  logic              ab_err,
    input  logic              end_evt,
    input  logic              non_octet,
    input  logic              crc_ok,
    input  logic              irq_en,
    output logic [STAT_W-1:0] stat,
    output logic              done,
    output logic              irq,
    output logic              abort_inc,
    output logic              crc_inc,
    output logic              hunt_req
);
    rx_stat_t nxt;
    logic     any_close;
    logic     any_err;

    // Selects the single highest-priority error class for this close.
    always_comb begin
        nxt           = '0;
        nxt.cd_lost   = cd_err;
        nxt.aborted   = ab_err && !cd_err;
        nxt.non_octet = end_evt && !cd_err && !ab_err && non_octet;
        nxt.crc_bad   = end_evt && !cd_err && !ab_err && !non_octet && !crc_ok;
        any_close     = cd_err || ab_err || end_evt;
        any_err       = (nxt != '0);
    end

    // Registers the status word and pulses the strobes for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat      <= '0;
            done      <= 1'b0;
            irq       <= 1'b0;
            abort_inc <= 1'b0;
            crc_inc   <= 1'b0;
            hunt_req  <= 1'b0;
        end else begin
            done      <= any_close;
            irq       <= any_err && irq_en;
            abort_inc <= nxt.aborted;
            crc_inc   <= nxt.crc_bad;
            hunt_req  <= any_err;
            if (any_close)
                stat <= nxt;
        end
    end
endmodule

// File: rtl/hdlc_rx_err_detect.sv
// Module: top of the HDLC receive frame error detector.
// Tracks whether a frame is open, derives the close events, and routes them
// to the packer and the classifier.
// Assumes the frame_start and frame_end cycles carry no line bit.
module hdlc_rx_err_detect #(
    parameter int WORD_W    = 16,
    parameter int RUN_LIMIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cd_hw_mode,
    input  logic              carrier,
    input  logic              irq_en,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              crc_ok,
    input  logic              line_vld,
    input  logic              line_bit,
    input  logic              line_keep,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic [3:0]        stat,
    output logic              irq,
    output logic              abort_inc,
    output logic              crc_inc,
    output logic              hunt_req
);
    logic active_q;
    logic run_hit;
    logic cd_err;
    logic ab_err;
    logic end_evt;
    logic push;
    logic drop;
    logic non_octet;

    // Close events in priority order, plus the packer controls.
    always_comb begin
        cd_err  = active_q && cd_hw_mode && !carrier;
        ab_err  = active_q && !cd_err && run_hit;
        end_evt = active_q && !cd_err && !ab_err && frame_end;
        push    = active_q && line_vld && line_keep && !cd_err && !ab_err && !frame_end;
        drop    = frame_start || cd_err || ab_err;
    end

    // Frame-open flag: set by frame_start, cleared by any close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (frame_start)
            active_q <= 1'b1;
        else if (cd_err || ab_err || end_evt)
            active_q <= 1'b0;
    end

    hdlc_rxe_ones_run #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (frame_start),
        .en     (active_q && !frame_end),
        .vld    (line_vld),
        .bit_in (line_bit),
        .hit    (run_hit)
    );

    hdlc_rxe_packer #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (drop),
        .push      (push),
        .bit_in    (line_bit),
        .flush     (end_evt),
        .non_octet (non_octet),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    hdlc_rxe_classify u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd_err    (cd_err),
        .ab_err    (ab_err),
        .end_evt   (end_evt),
        .non_octet (non_octet),
        .crc_ok    (crc_ok),
        .irq_en    (irq_en),
        .stat      (stat),
        .done      (done),
        .irq       (irq),
        .abort_inc (abort_inc),
        .crc_inc   (crc_inc),
        .hunt_req  (hunt_req)
    );
endmodule

// File: rtl/hdlc_rx_err_detect_chk.sv
// Checker: temporal properties of the detector's ports, bound to the top.
module hdlc_rx_err_detect_chk
    import hdlc_rxe_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cd_hw_mode,
    input logic              carrier,
    input logic              irq_en,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              done,
    input logic [3:0]        stat,
    input logic              irq,
    input logic              abort_inc,
    input logic              crc_inc,
    input logic              hunt_req
);
    AST_STAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(stat)); // R12
    AST_CD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stat[ST_CD_BIT]) |-> $past(cd_hw_mode && !carrier)); // R3
    AST_ABORT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_inc |-> (done && stat == 4'b0100)); // R4
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (stat[ST_CD_BIT] || stat[ST_AB_BIT])) |-> !wr_en); // R4
    AST_CRC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_inc |-> (done && stat == 4'b0001)); // R8
    AST_NONOCTET_NO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stat[ST_NO_BIT]) |-> !crc_inc); // R6
    AST_HUNT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |-> (done && stat != 4'b0000)); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && stat != 4'b0000 && $past(irq_en))); // R10
endmodule

bind hdlc_rx_err_detect hdlc_rx_err_detect_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cd_hw_mode (cd_hw_mode),
    .carrier    (carrier),
    .irq_en     (irq_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .done       (done),
    .stat       (stat),
    .irq        (irq),
    .abort_inc  (abort_inc),
    .crc_inc    (crc_inc),
    .hunt_req   (hunt_req)
);

// File: tb/hdlc_rx_err_detect_test.sv
// Bench: sweeps frame lengths, bit patterns, abort and carrier positions.
// Expected words and status values are computed arithmetically.
module hdlc_rx_err_detect_test;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cd_hw_mode = 1'b0, carrier = 1'b1, irq_en = 1'b0;
    logic frame_start = 1'b0, frame_end = 1'b0, crc_ok = 1'b1;
    logic line_vld = 1'b0, line_bit = 1'b0, line_keep = 1'b0;
    logic wr_en, done, irq, abort_inc, crc_inc, hunt_req;
    logic [W-1:0] wr_data;
    logic [3:0] stat;

    always #10 clk = ~clk;

    hdlc_rx_err_detect #(.WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cd_hw_mode(cd_hw_mode), .carrier(carrier),
        .irq_en(irq_en), .frame_start(frame_start), .frame_end(frame_end),
        .crc_ok(crc_ok), .line_vld(line_vld), .line_bit(line_bit),
        .line_keep(line_keep), .wr_en(wr_en), .wr_data(wr_data), .done(done),
        .stat(stat), .irq(irq), .abort_inc(abort_inc), .crc_inc(crc_inc),
        .hunt_req(hunt_req)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] expq[$];
    longint acc;
    int nb;
    bit exp_done = 0;
    bit pend_start = 0;
    bit g_done, g_irq, g_hunt, g_ab, g_crc;
    logic [3:0] g_stat;

    task automatic chk(string req, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Advances one cycle and samples the outputs at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (wr_en) begin
            if (expq.size() == 0) chk("R2/R4", "unexpected write", wr_data, 0);
            else chk("R2/R7", "data word", wr_data, expq.pop_front());
        end
        if (done) begin
            g_done = 1; g_stat = stat; g_irq = irq; g_hunt = hunt_req;
            g_ab = abort_inc; g_crc = crc_inc;
            if (!exp_done) chk("R4", "spurious done", 1, 0);
        end else if (irq || hunt_req || abort_inc || crc_inc) begin
            chk("R10", "strobe without done", 1, 0);
        end
    endtask

    function automatic bit dbit(int pat, int j);
        if (pat == 0) return 1'b1;
        if (pat == 1) return j[0];
        return ((j * 7 + pat * 3) % 5) < 2;
    endfunction

    task automatic model_push(bit b);
        acc = acc * 2 + longint'(b);
        nb++;
        if (nb == W) begin
            expq.push_back(acc[W-1:0]);
            acc = 0;
            nb = 0;
        end
    endtask

    task automatic line(bit b, bit keep);
        line_vld = 1; line_bit = b; line_keep = keep;
        step();
        line_vld = 0; line_keep = 0; line_bit = 0;
    endtask

    task automatic begin_frame();
        if (!pend_start) begin
            frame_start = 1;
            step();
            frame_start = 0;
        end
        pend_start = 0;
        acc = 0;
        nb = 0;
    endtask

    // Sends len stuffed content bits; returns the count of trailing ones.
    task automatic send_data(int len, int pat, output int ones);
        ones = 0;
        for (int j = 0; j < len; j++) begin
            bit b = dbit(pat, j);
            model_push(b);
            line(b, 1'b1);
            ones = b ? ones + 1 : 0;
            if (ones == 5) begin
                line(1'b0, 1'b0);
                ones = 0;
            end
        end
    endtask

    task automatic check_close(string req, int est, bit ien);
        chk(req, "done", g_done, 1);
        chk(req, "stat", g_stat, est);
        chk("R10", "irq", g_irq, (est != 0) && ien);
        chk(req, "hunt_req", g_hunt, est != 0);
        chk(req, "abort_inc", g_ab, est == 4);
        chk(req, "crc_inc", g_crc, est == 1);
        chk("R2", "words pending", expq.size(), 0);
    endtask

    task automatic run_frame(int len, int pat, bit crc, bit ien, bit b2b);
        int ones;
        int est;
        irq_en = ien;
        begin_frame();
        send_data(len, pat, ones);
        if (nb > 0) begin
            if (len % 8 != 0) begin
                int p = 8 - (nb % 8);
                expq.push_back(W'((acc << p) + (longint'(1) << (p - 1))));
            end else begin
                expq.push_back(acc[W-1:0]);
            end
        end
        frame_end = 1; crc_ok = crc; frame_start = b2b;
        exp_done = 1; g_done = 0;
        step();
        frame_end = 0; frame_start = 0; crc_ok = 1; exp_done = 0;
        est = (len % 8 != 0) ? 2 : (crc ? 0 : 1);
        check_close(est == 2 ? "R6" : (est == 1 ? "R8" : (b2b ? "R11" : "R9")), est, ien);
        pend_start = b2b;
    endtask

    // Seven ones after pre bits; optional carrier drop on the seventh.
    task automatic abort_frame(int pre, bit ien, bit cd_too);
        int ones;
        irq_en = ien;
        cd_hw_mode = 1;
        begin_frame();
        send_data(pre, 2, ones);
        model_push(1'b0);
        line(1'b0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            model_push(1'b1);
            line(1'b1, 1'b1);
        end
        if (cd_too) carrier = 0;
        exp_done = 1; g_done = 0;
        line(1'b1, 1'b1);
        exp_done = 0; carrier = 1;
        for (int k = 0; k < 5; k++) line(k[0], 1'b1);
        if (cd_too) check_close("R5", 8, ien);
        else check_close("R4", 4, ien);
        cd_hw_mode = 0;
    endtask

    task automatic carrier_frame(int pre, bit ien);
        int ones;
        irq_en = ien;
        cd_hw_mode = 1;
        begin_frame();
        send_data(pre, 1, ones);
        carrier = 0; exp_done = 1; g_done = 0;
        line(1'b0, 1'b1);
        exp_done = 0; carrier = 1;
        for (int k = 0; k < 3; k++) line(1'b1, 1'b1);
        check_close("R3", 8, ien);
        cd_hw_mode = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "outputs after reset",
            {wr_en, done, stat, irq, abort_inc, crc_inc, hunt_req}, 0);
        rst_n = 1;
        step();
        for (int len = 1; len <= 40; len++)
            for (int pat = 0; pat < 3; pat++)
                run_frame(len, pat, ((len + pat) % 3) != 0, len[0], (len % 4) == 0);
        for (int pre = 0; pre <= 20; pre++) abort_frame(pre, pre[0], 1'b0);
        for (int pre = 0; pre <= 20; pre++) abort_frame(pre, !pre[0], 1'b1);
        for (int pre = 0; pre <= 20; pre++) carrier_frame(pre, pre[1]);
        // R3: carrier ignored when not hardware-controlled.
        carrier = 0;
        for (int len = 14; len <= 18; len++) run_frame(len, 2, 1'b0, 1'b1, 1'b0);
        carrier = 1;
        run_frame(24, 1, 1'b1, 1'b1, 1'b0);
        repeat (3) step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule